// File: doc/BRIEF.md
# Self-Synchronizing PRBS Bit Error Checker

This block measures bit errors on a received serial stream that is expected to carry a pseudo-random binary sequence. It is told only which generator polynomial the sender uses. It needs no seed and no phase reference. When a measurement starts, a local shift register takes its contents from the incoming bits. Once the register is full, the block stops loading it from the line. From then on the register runs on its own feedback taps and predicts every following bit.

Each received bit after that point is compared with the prediction. The block counts how many bits it compared and how many of them disagreed. Because the register seeds itself from the line, the measurement can begin anywhere in the stream, and any fixed delay between the source and the checker has no effect.

If a burst of errors shows that the register has lost its lock, the block raises a sticky loss flag and refills the register from the line by itself. Dividing the error count by the bit count is left to the consumer.

Top module: `prbs_err_checker`

## Requirements
- R1: `poly_sel_i` picks the generator. 2'b00 is x^9+x^5+1 (register length 9), 2'b01 is x^15+x^14+1 (length 15), and 2'b10 or 2'b11 is x^23+x^18+1 (length 23). The polynomial is the only configuration: there is no seed input. A stream built from a different polynomial is not tracked.
- R2: A fill starts after reset, after a start pulse, or after a loss event. During a fill, the first L valid bits (L is the register length) are loaded into the register and are not counted. `sync_o` rises on the cycle after the L-th valid fill bit has been clocked.
- R3: Once `sync_o` is high, each valid bit adds one to `bit_cnt_o`. A bit that differs from the prediction also adds one to `err_cnt_o`. A wrong received bit does not disturb later predictions.
- R4: Locking works from any phase of the incoming sequence.
- R5: A cycle with `valid_i` low has no effect on the register, the counters or the flags, whatever `data_i` carries.
- R6: A one-cycle `start_i` has the following effects on the next cycle: both counters read zero, `sync_o` and `los_o` are low, and a new fill is under way. Data presented on the start cycle is ignored even when `valid_i` is high.
- R7: Compared bits are grouped into windows of 64, the first window starting with the first compared bit after sync. When the errors inside one window reach LOS_ERRS (default 8), the following happens on the next cycle. `los_o` goes high and `sync_o` goes low, and the error that triggered it has been counted. A refill then begins with the next valid bit. `los_o` stays high until the next start pulse.
- R8: Errors that stay below LOS_ERRS within every window never raise `los_o`, even when their total across windows is larger.
- R9: Both counters saturate at their all-ones value; an error is still counted while `bit_cnt_o` is saturated.
- R10: After a synchronous active-low reset, both counters are zero and `sync_o` and `los_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle measurement start |
| valid_i | input | 1 | `data_i` carries a bit this cycle |
| data_i | input | 1 | Received serial bit |
| poly_sel_i | input | 2 | Generator polynomial select |
| bit_cnt_o | output | CNT_W | Compared bits, saturating |
| err_cnt_o | output | CNT_W | Mismatched bits, saturating |
| sync_o | output | 1 | Register is in free-running prediction |
| los_o | output | 1 | Sticky loss-of-sync flag |

## Verification
Every result is due one clock after the edge that takes the deciding input, because counters and flags come directly from registers. This applies to the count step for a compared bit, the rise of `sync_o` after the L-th fill bit, the loss flag after the threshold error, and the clearing after a start pulse. The bench drives inputs on the falling edge. It reads the outputs on the falling edge that follows the rising edge which consumed the last driven bit, so each check lands exactly one edge after its stimulus. Expected counts are derived from the number of bits sent past the fill length and the positions at which the bench inverts bits, over all polynomial codes and several stream phases.

// File: rtl/prbs_chk_pkg.sv
// Package: shared state type and polynomial table for the PRBS error checker.
// Assumes the longest supported register is 23 bits.
package prbs_chk_pkg;

    localparam int unsigned LFSR_MAX = 23;

    typedef enum logic {
        ST_FILL  = 1'b0,
        ST_TRACK = 1'b1
    } trk_state_e;

    // Register length for a polynomial select code.
    function automatic int unsigned poly_len(input logic [1:0] sel);
        case (sel)
            2'b00:   poly_len = 9;
            2'b01:   poly_len = 15;
            default: poly_len = 23;
        endcase
    endfunction

    // Inner feedback tap for a polynomial select code.
    function automatic int unsigned poly_tap(input logic [1:0] sel);
        case (sel)
            2'b00:   poly_tap = 5;
            2'b01:   poly_tap = 14;
            default: poly_tap = 18;
        endcase
    endfunction

endpackage

// File: rtl/prbs_ref_lfsr.sv
// Module: reference shift register. In fill mode it shifts in the received
// bit; in track mode it shifts in its own prediction. Bit 0 holds the newest
// bit. Assumes MAX_LEN >= the longest polynomial in the package.
module prbs_ref_lfsr
    import prbs_chk_pkg::*;
#(
    parameter int unsigned MAX_LEN = LFSR_MAX,
    parameter int unsigned LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en_i,
    input  logic             fill_mode_i,
    input  logic             rx_bit_i,
    input  logic [1:0]       poly_sel_i,
    output logic             pred_bit_o,
    output logic [LEN_W-1:0] fill_len_o
);

    logic [MAX_LEN-1:0] state_q;
    logic               next_in;

    // Prediction from the two taps of the selected polynomial.
    always_comb begin
        pred_bit_o = state_q[poly_len(poly_sel_i) - 1] ^ state_q[poly_tap(poly_sel_i) - 1];
        fill_len_o = LEN_W'(poly_len(poly_sel_i));
        next_in    = fill_mode_i ? rx_bit_i : pred_bit_o;
    end

    // Shift register advance on each accepted bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else if (shift_en_i) begin
            state_q <= {state_q[MAX_LEN-2:0], next_in};
        end
    end

endmodule

// File: rtl/prbs_sync_ctrl.sv
// Module: fill/track sequencer and loss-of-sync monitor. Counts fill bits,
// tracks errors per window of compared bits and forces a refill when a window
// collects LOS_ERRS errors. Assumes WIN is a power of two and LOS_ERRS <= WIN.
module prbs_sync_ctrl
    import prbs_chk_pkg::*;
#(
    parameter int unsigned WIN      = 64,
    parameter int unsigned LOS_ERRS = 8,
    parameter int unsigned LEN_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             valid_i,
    input  logic             mismatch_i,
    input  logic [LEN_W-1:0] fill_len_i,
    output logic             fill_mode_o,
    output logic             cmp_en_o,
    output logic             err_hit_o,
    output logic             sync_o,
    output logic             los_o
);

    localparam int unsigned WIN_W = $clog2(WIN);
    localparam int unsigned ERR_W = $clog2(WIN + 1);

    trk_state_e       state_q;
    logic [LEN_W-1:0] fill_cnt_q;
    logic [WIN_W-1:0] win_cnt_q;
    logic [ERR_W-1:0] win_err_q;
    logic [ERR_W-1:0] win_err_nxt;
    logic             los_q;
    logic             los_evt;
    logic             win_end;
    logic             fill_done;

    // Per-cycle decisions derived from state and inputs.
    always_comb begin
        fill_mode_o = (state_q == ST_FILL);
        cmp_en_o    = valid_i && !start_i && (state_q == ST_TRACK);
        err_hit_o   = cmp_en_o && mismatch_i;
        win_err_nxt = win_err_q + ERR_W'(err_hit_o);
        los_evt     = err_hit_o && (win_err_nxt >= ERR_W'(LOS_ERRS));
        win_end     = cmp_en_o && (win_cnt_q == WIN_W'(WIN - 1));
        fill_done   = valid_i && (fill_cnt_q == fill_len_i - LEN_W'(1));
        sync_o      = (state_q == ST_TRACK);
        los_o       = los_q;
    end

    // Mode sequencing: fill, track, refill on loss.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            state_q    <= ST_FILL;
            fill_cnt_q <= '0;
        end else if (state_q == ST_FILL) begin
            if (fill_done) begin
                state_q    <= ST_TRACK;
                fill_cnt_q <= '0;
            end else if (valid_i) begin
                fill_cnt_q <= fill_cnt_q + LEN_W'(1);
            end
        end else if (los_evt) begin
            state_q    <= ST_FILL;
            fill_cnt_q <= '0;
        end
    end

    // Error window bookkeeping over compared bits.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i || los_evt || (state_q == ST_FILL)) begin
            win_cnt_q <= '0;
            win_err_q <= '0;
        end else if (win_end) begin
            win_cnt_q <= '0;
            win_err_q <= '0;
        end else if (cmp_en_o) begin
            win_cnt_q <= win_cnt_q + WIN_W'(1);
            win_err_q <= win_err_nxt;
        end
    end

    // Sticky loss flag, cleared only by start or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            los_q <= 1'b0;
        end else if (los_evt) begin
            los_q <= 1'b1;
        end
    end

endmodule

// File: rtl/prbs_sat_cnt.sv
// Module: saturating up-counter with synchronous clear. Clear wins over
// increment; at all-ones the count holds.
module prbs_sat_cnt #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         inc_i,
    output logic [W-1:0] count_o
);

    // Count with clear priority and saturation.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            count_o <= '0;
        end else if (inc_i && (count_o != {W{1'b1}})) begin
            count_o <= count_o + W'(1);
        end
    end

endmodule

// File: rtl/prbs_err_checker.sv
// Module: top of the self-synchronizing PRBS bit error checker. Joins the
// reference register, the sequencer and two saturating counters. Assumes
// start_i is a single-cycle pulse and poly_sel_i is steady during a run.
module prbs_err_checker
    import prbs_chk_pkg::*;
#(
    parameter int unsigned CNT_W    = 32,
    parameter int unsigned WIN      = 64,
    parameter int unsigned LOS_ERRS = 8,
    parameter int unsigned MAX_LEN  = LFSR_MAX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             valid_i,
    input  logic             data_i,
    input  logic [1:0]       poly_sel_i,
    output logic [CNT_W-1:0] bit_cnt_o,
    output logic [CNT_W-1:0] err_cnt_o,
    output logic             sync_o,
    output logic             los_o
);

    localparam int unsigned LEN_W = $clog2(MAX_LEN + 1);
    localparam int unsigned N_CNT = 2;

    logic             pred_bit;
    logic [LEN_W-1:0] fill_len;
    logic             fill_mode;
    logic             cmp_en;
    logic             err_hit;
    logic             shift_en;
    logic [N_CNT-1:0] cnt_inc;
    logic [CNT_W-1:0] cnt_val [N_CNT];

    // Accept a bit whenever valid and not overridden by a start.
    always_comb begin
        shift_en   = valid_i && !start_i;
        cnt_inc[0] = cmp_en;
        cnt_inc[1] = err_hit;
        bit_cnt_o  = cnt_val[0];
        err_cnt_o  = cnt_val[1];
    end

    prbs_ref_lfsr #(
        .MAX_LEN (MAX_LEN),
        .LEN_W   (LEN_W)
    ) u_lfsr (
        .clk         (clk),
        .rst_n       (rst_n),
        .shift_en_i  (shift_en),
        .fill_mode_i (fill_mode),
        .rx_bit_i    (data_i),
        .poly_sel_i  (poly_sel_i),
        .pred_bit_o  (pred_bit),
        .fill_len_o  (fill_len)
    );

    prbs_sync_ctrl #(
        .WIN      (WIN),
        .LOS_ERRS (LOS_ERRS),
        .LEN_W    (LEN_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .valid_i     (valid_i),
        .mismatch_i  (data_i ^ pred_bit),
        .fill_len_i  (fill_len),
        .fill_mode_o (fill_mode),
        .cmp_en_o    (cmp_en),
        .err_hit_o   (err_hit),
        .sync_o      (sync_o),
        .los_o       (los_o)
    );

    // One saturating counter per statistic: index 0 bits, index 1 errors.
    for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
        prbs_sat_cnt #(
            .W (CNT_W)
        ) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear_i (start_i),
            .inc_i   (cnt_inc[k]),
            .count_o (cnt_val[k])
        );
    end

endmodule

// File: rtl/prbs_err_checker_chk.sv
// Module: property checker for the PRBS error checker, bound to the top.
// Observes ports only.
module prbs_err_checker_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             valid_i,
    input logic [CNT_W-1:0] bit_cnt_o,
    input logic [CNT_W-1:0] err_cnt_o,
    input logic             sync_o,
    input logic             los_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (bit_cnt_o == '0) && (err_cnt_o == '0) && !sync_o && !los_o); // R6

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i && !start_i) |=> $stable(bit_cnt_o) && $stable(err_cnt_o) && $stable(sync_o) && $stable(los_o)); // R5

    AST_FILL_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_o && !start_i) |=> $stable(bit_cnt_o) && $stable(err_cnt_o)); // R2

    AST_ERR_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (err_cnt_o == $past(err_cnt_o)) || (err_cnt_o == $past(err_cnt_o) + CNT_W'(1))); // R3

    AST_ERR_NOT_ABOVE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt_o <= bit_cnt_o); // R3

    AST_BIT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        ((bit_cnt_o == CNT_MAX) && !start_i) |=> (bit_cnt_o == CNT_MAX)); // R9

    AST_LOS_DROPS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(los_o) |-> !sync_o); // R7

endmodule

bind prbs_err_checker prbs_err_checker_chk #(
    .CNT_W (CNT_W)
) u_prbs_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .valid_i   (valid_i),
    .bit_cnt_o (bit_cnt_o),
    .err_cnt_o (err_cnt_o),
    .sync_o    (sync_o),
    .los_o     (los_o)
);

// File: tb/test_prbs_err_checker.sv
`timescale 1ns/1ps
// Bench: sweeps polynomials and stream phases, then exercises gaps, start,
// loss-of-sync, windowing and saturation with a small counter width.
module test_prbs_err_checker;

    localparam int unsigned CNT_W    = 10;
    localparam int unsigned LOS_ERRS = 8;
    localparam int unsigned WIN      = 64;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             valid_i = 1'b0;
    logic             data_i = 1'b0;
    logic [1:0]       poly_sel_i = 2'b00;
    logic [CNT_W-1:0] bit_cnt_o;
    logic [CNT_W-1:0] err_cnt_o;
    logic             sync_o;
    logic             los_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic [22:0] g;
    int bl = 9;
    int bt = 5;

    prbs_err_checker #(
        .CNT_W    (CNT_W),
        .WIN      (WIN),
        .LOS_ERRS (LOS_ERRS)
    ) i_prbs_err_checker (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .valid_i    (valid_i),
        .data_i     (data_i),
        .poly_sel_i (poly_sel_i),
        .bit_cnt_o  (bit_cnt_o),
        .err_cnt_o  (err_cnt_o),
        .sync_o     (sync_o),
        .los_o      (los_o)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic gen_poly(input logic [1:0] sel);
        case (sel)
            2'b00:   begin bl = 9;  bt = 5;  end
            2'b01:   begin bl = 15; bt = 14; end
            default: begin bl = 23; bt = 18; end
        endcase
    endtask

    task automatic next_bit(output logic b);
        b = g[bl-1] ^ g[bt-1];
        g = {g[21:0], b};
    endtask

    task automatic send(input logic flip);
        logic b;
        next_bit(b);
        @(negedge clk);
        start_i = 1'b0;
        valid_i = 1'b1;
        data_i  = b ^ flip;
    endtask

    task automatic send_n(input int n);
        for (int i = 0; i < n; i++) send(1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            valid_i = 1'b0;
            data_i  = ~data_i;
        end
    endtask

    task automatic do_start(input logic v, input logic d);
        @(negedge clk);
        start_i = 1'b1;
        valid_i = v;
        data_i  = d;
        @(negedge clk);
        start_i = 1'b0;
        valid_i = 1'b0;
    endtask

    task automatic seed(input int skip);
        logic b;
        g = 23'h1ACE5;
        for (int i = 0; i < skip; i++) next_bit(b);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual %0d expected %0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check("R10 bit_cnt", bit_cnt_o, 0);
        check("R10 err_cnt", err_cnt_o, 0);
        check("R10 sync", sync_o, 0);
        check("R10 los", los_o, 0);

        // R1 R2 R3 R4: every select code, several phases, errors at known spots
        for (int p = 0; p < 4; p++) begin
            for (int ph = 0; ph < 3; ph++) begin
                gen_poly(p[1:0]);
                poly_sel_i = p[1:0];
                seed(ph * 41 + 3 + p * 7);
                do_start(1'b0, 1'b0);
                send_n(bl - 1);
                idle(1);
                check("R2 sync low before last fill bit", sync_o, 0);
                send_n(1);
                idle(1);
                check("R2 sync after fill", sync_o, 1);
                check("R2 fill bits not counted", bit_cnt_o, 0);
                for (int i = 0; i < 150; i++) send((i == 10) || (i == 50) || (i == 120));
                idle(1);
                check("R4 bits counted from any phase", bit_cnt_o, 150);
                check("R1 R3 errors counted", err_cnt_o, 3);
                check("R3 no loss", los_o, 0);
            end
        end

        // R1: stream of one polynomial against a different select
        gen_poly(2'b01);
        seed(17);
        poly_sel_i = 2'b00;
        do_start(1'b0, 1'b0);
        send_n(120);
        idle(1);
        check("R1 mismatched polynomial not tracked", los_o, 1);

        // R6: data on a valid start cycle is ignored
        gen_poly(2'b00);
        poly_sel_i = 2'b00;
        seed(29);
        do_start(1'b1, 1'b1);
        check("R6 counters cleared", bit_cnt_o + err_cnt_o, 0);
        check("R6 los cleared", los_o, 0);
        send_n(bl - 1);
        idle(1);
        check("R6 start-cycle bit not loaded", sync_o, 0);
        send_n(1);
        idle(1);
        check("R6 sync after full fill", sync_o, 1);

        // R5: gaps with toggling data leave everything unchanged
        send_n(20);
        idle(6);
        check("R5 bits held over gap", bit_cnt_o, 20);
        send_n(30);
        idle(1);
        check("R5 bits after gap", bit_cnt_o, 50);
        check("R5 prediction held over gap", err_cnt_o, 0);

        // R5: gap in the middle of a fill
        do_start(1'b0, 1'b0);
        send_n(4);
        idle(5);
        send_n(bl - 5);
        idle(1);
        check("R5 fill paused by gap", sync_o, 0);
        send_n(1);
        idle(1);
        check("R5 fill completes on valid bits only", sync_o, 1);

        // R8: below-threshold errors in two windows, no loss
        send_n(0);
        do_start(1'b0, 1'b0);
        send_n(bl);
        for (int i = 0; i < 2 * WIN + 10; i++)
            send(((i < LOS_ERRS - 1)) || ((i >= WIN) && (i < WIN + LOS_ERRS - 1)));
        idle(1);
        check("R8 no loss across windows", los_o, 0);
        check("R8 errors total", err_cnt_o, 2 * (LOS_ERRS - 1));
        check("R8 sync kept", sync_o, 1);

        // R7: threshold errors in one window
        do_start(1'b0, 1'b0);
        send_n(bl);
        send_n(5);
        for (int i = 0; i < LOS_ERRS; i++) send(1'b1);
        idle(1);
        check("R7 los raised", los_o, 1);
        check("R7 sync dropped", sync_o, 0);
        check("R7 triggering error counted", err_cnt_o, LOS_ERRS);
        check("R7 bits at loss", bit_cnt_o, 5 + LOS_ERRS);
        send_n(bl - 1);
        idle(1);
        check("R7 refill in progress", sync_o, 0);
        send_n(1);
        idle(1);
        check("R7 resync after refill", sync_o, 1);
        check("R7 los sticky", los_o, 1);
        send_n(20);
        idle(1);
        check("R7 clean after resync", err_cnt_o, LOS_ERRS);
        check("R7 bits after resync", bit_cnt_o, 25 + LOS_ERRS);

        // R6: start clears after a loss
        do_start(1'b0, 1'b0);
        check("R6 bits cleared", bit_cnt_o, 0);
        check("R6 errors cleared", err_cnt_o, 0);
        check("R6 los cleared after loss", los_o, 0);
        check("R6 sync cleared", sync_o, 0);

        // R9: saturation of the bit counter, errors still counted
        send_n(bl);
        send_n(1100);
        idle(1);
        check("R9 bit counter saturates", bit_cnt_o, (1 << CNT_W) - 1);
        check("R9 no errors", err_cnt_o, 0);
        send(1'b1);
        idle(1);
        check("R9 error counted while saturated", err_cnt_o, 1);
        check("R9 bits stay saturated", bit_cnt_o, (1 << CNT_W) - 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule